// File: doc/BRIEF.md
# Emulated Serial Port Register Bank

This block is a small register bank that sits between a host bus and a local embedded processor. The processor stands in for a serial port controller in firmware. Through its own bus the host sees a slice of the usual 16550-style register map: a scratch byte, the two baud divisor bytes, and a modem status byte. The local processor decides the modem line levels by writing them. It reads back what the host stored through a narrow read-only window.

Host writes to either divisor byte raise a sticky interrupt request towards the local processor. The processor can then fetch the new divisor and reprogram its own bit timing. The request records which byte was written and stays up until the processor clears it with a write-one-to-clear strobe. The bank derives the change flags of the modem status byte from successive line writes. A host read of the status byte consumes those flags.

Top module: `uart_mirror_regs`

## Requirements
- R1: After reset the scratch byte, both divisor bytes, the modem status byte and both interrupt flags are 0.
- R2: A local line write (`line_we`) stores `line_wdata` as the modem line levels. These appear in the status byte as bit 7 carrier detect (wdata[3]), bit 6 ring (wdata[2]), bit 5 data set ready (wdata[1]) and bit 4 clear to send (wdata[0]), from the cycle after the write.
- R3: Status bit 3 (carrier detect), bit 1 (data set ready) and bit 0 (clear to send) are set when a line write changes that line. Writing the same level again sets nothing.
- R4: Status bit 2 is set only when a line write takes the ring line from 1 to 0. A 0-to-1 change leaves it alone.
- R5: A host read of the status byte (offset 6) clears bits 3..0 at the end of that cycle. A change flag raised by a line write in the same cycle survives the clear.
- R6: The scratch byte at host offset 7 is host read/write, and a host write to it sets no interrupt flag.
- R7: With `dlab`=1, host offset 0 is the divisor low byte and offset 1 the high byte. With `dlab`=0 those offsets do not touch the divisor bytes and `host_hit` stays 0. Offsets 2..5 never hit, and host writes to offset 6 change nothing.
- R8: A host write to the divisor low byte sets interrupt flag bit 0, and a write to the high byte sets bit 1. `irq_req` is 1 while either flag is set.
- R9: A flag stays set until the local processor pulses the matching `irq_clr` bit. If a set and a clear of the same flag happen in one cycle, the set wins.
- R10: The local window returns the scratch byte at address F7 hex, the divisor low byte at F8 and the high byte at F9. Every other address returns 0.
- R11: Host read data and `host_hit` reflect the registers in the same cycle as the strobe. `host_rdata` is 0 whenever no read hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | Host write qualifier |
| host_rd | input | 1 | Host read qualifier |
| host_addr | input | 3 | Host register offset |
| host_wdata | input | 8 | Host write data |
| dlab | input | 1 | Divisor access enable from line control logic |
| host_rdata | output | 8 | Host read data, same cycle |
| host_hit | output | 1 | Access decoded by this bank |
| line_we | input | 1 | Local write strobe for modem line levels |
| line_wdata | input | 4 | Line levels {carrier, ring, data set ready, clear to send} |
| loc_rd_addr | input | 8 | Local read window address |
| loc_rdata | output | 8 | Local read data, same cycle |
| irq_clr | input | 2 | Write-one-to-clear for the interrupt flags |
| irq_flags | output | 2 | Sticky flags: bit 0 low byte, bit 1 high byte written |
| irq_req | output | 1 | Interrupt request to the local processor |

## Verification
The bench builds the bank with its default widths: an 8-bit data path, a 3-bit host offset and an 8-bit local window based at F7 hex. With those defaults the whole host map of eight offsets and the local window edges at F6 and FA can be exercised directly. The random phase toggles `dlab` and overlaps line writes, status reads and flag clears in the same cycle. That overlap brings the set-versus-clear races of R5 and R9 within reach.

// File: rtl/umr_pkg.sv
package umr_pkg;
    localparam int OFS_DLL = 0;
    localparam int OFS_DLM = 1;
    localparam int OFS_MSR = 6;
    localparam int OFS_SCR = 7;
    localparam int NUM_LINES = 4;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;
endpackage

// File: rtl/umr_modem_status.sv
module umr_modem_status
    import umr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_we,
    input  line_t      line_wdata,
    input  logic       msr_rd,
    output logic [7:0] msr
);
    typedef struct packed {
        line_t                  lines;
        logic [NUM_LINES-1:0]   delta;
    } ms_state_t;

    ms_state_t st_d, st_q;
    logic [NUM_LINES-1:0] event_w;

    always_comb begin
        event_w = '0;
        if (line_we) begin
            event_w[3] = line_wdata.dcd ^ st_q.lines.dcd;
            event_w[2] = st_q.lines.ri & ~line_wdata.ri;
            event_w[1] = line_wdata.dsr ^ st_q.lines.dsr;
            event_w[0] = line_wdata.cts ^ st_q.lines.cts;
        end
        st_d = st_q;
        if (line_we) st_d.lines = line_wdata;
        st_d.delta = (msr_rd ? '0 : st_q.delta) | event_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msr = {st_q.lines, st_q.delta};
endmodule

// File: rtl/umr_host_regs.sv
module umr_host_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_scr,
    input  logic          wr_dll,
    input  logic          wr_dlm,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    clr,
    output logic [DW-1:0] scr,
    output logic [DW-1:0] dll,
    output logic [DW-1:0] dlm,
    output logic [1:0]    flags
);
    typedef struct packed {
        logic [DW-1:0] scr;
        logic [DW-1:0] dll;
        logic [DW-1:0] dlm;
        logic [1:0]    flg;
    } hr_state_t;

    hr_state_t st_d, st_q;
    logic [1:0] set_w;

    assign set_w = {wr_dlm, wr_dll};

    always_comb begin
        st_d = st_q;
        if (wr_scr) st_d.scr = wdata;
        if (wr_dll) st_d.dll = wdata;
        if (wr_dlm) st_d.dlm = wdata;
        for (int i = 0; i < 2; i++) begin
            st_d.flg[i] = set_w[i] | (st_q.flg[i] & ~clr[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scr   = st_q.scr;
    assign dll   = st_q.dll;
    assign dlm   = st_q.dlm;
    assign flags = st_q.flg;
endmodule

// File: rtl/umr_local_view.sv
module umr_local_view #(
    parameter int             DW       = 8,
    parameter int             LAW      = 8,
    parameter logic [LAW-1:0] LOC_BASE = 8'hF7
) (
    input  logic [LAW-1:0] addr,
    input  logic [DW-1:0]  scr,
    input  logic [DW-1:0]  dll,
    input  logic [DW-1:0]  dlm,
    output logic [DW-1:0]  rdata
);
    localparam int NSLOT = 3;
    logic [NSLOT-1:0][DW-1:0] slot_w;
    logic [NSLOT-1:0]         match_w;

    assign slot_w[0] = scr;
    assign slot_w[1] = dll;
    assign slot_w[2] = dlm;

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign match_w[g] = (addr == LAW'(LOC_BASE + g));
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (match_w[i]) rdata = slot_w[i];
        end
    end
endmodule

// File: rtl/uart_mirror_regs.sv
module uart_mirror_regs
    import umr_pkg::*;
#(
    parameter int             DW       = 8,
    parameter int             HAW      = 3,
    parameter int             LAW      = 8,
    parameter logic [LAW-1:0] LOC_BASE = 8'hF7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_sel,
    input  logic           host_wr,
    input  logic           host_rd,
    input  logic [HAW-1:0] host_addr,
    input  logic [DW-1:0]  host_wdata,
    input  logic           dlab,
    output logic [DW-1:0]  host_rdata,
    output logic           host_hit,
    input  logic           line_we,
    input  logic [3:0]     line_wdata,
    input  logic [LAW-1:0] loc_rd_addr,
    output logic [DW-1:0]  loc_rdata,
    input  logic [1:0]     irq_clr,
    output logic [1:0]     irq_flags,
    output logic           irq_req
);
    logic hit_scr, hit_msr, hit_dll, hit_dlm, any_hit;
    logic wr_en, rd_en, msr_rd;
    logic [DW-1:0] scr_w, dll_w, dlm_w;
    logic [7:0]    msr_w;

    assign hit_scr = (host_addr == HAW'(OFS_SCR));
    assign hit_msr = (host_addr == HAW'(OFS_MSR));
    assign hit_dll = dlab & (host_addr == HAW'(OFS_DLL));
    assign hit_dlm = dlab & (host_addr == HAW'(OFS_DLM));
    assign any_hit = hit_scr | hit_msr | hit_dll | hit_dlm;

    assign wr_en  = host_sel & host_wr;
    assign rd_en  = host_sel & host_rd;
    assign msr_rd = rd_en & hit_msr;
    assign host_hit = host_sel & (host_wr | host_rd) & any_hit;

    umr_modem_status u_ms (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_we    (line_we),
        .line_wdata (line_t'(line_wdata)),
        .msr_rd     (msr_rd),
        .msr        (msr_w)
    );

    umr_host_regs #(.DW(DW)) u_hr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_scr (wr_en & hit_scr),
        .wr_dll (wr_en & hit_dll),
        .wr_dlm (wr_en & hit_dlm),
        .wdata  (host_wdata),
        .clr    (irq_clr),
        .scr    (scr_w),
        .dll    (dll_w),
        .dlm    (dlm_w),
        .flags  (irq_flags)
    );

    umr_local_view #(.DW(DW), .LAW(LAW), .LOC_BASE(LOC_BASE)) u_lv (
        .addr  (loc_rd_addr),
        .scr   (scr_w),
        .dll   (dll_w),
        .dlm   (dlm_w),
        .rdata (loc_rdata)
    );

    always_comb begin
        host_rdata = '0;
        if (rd_en) begin
            if (hit_scr)      host_rdata = scr_w;
            else if (hit_msr) host_rdata = DW'(msr_w);
            else if (hit_dll) host_rdata = dll_w;
            else if (hit_dlm) host_rdata = dlm_w;
        end
    end

    assign irq_req = |irq_flags;
endmodule

// File: rtl/umr_checker.sv
module umr_checker #(
    parameter int DW  = 8,
    parameter int HAW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           host_sel,
    input logic           host_wr,
    input logic           host_rd,
    input logic [HAW-1:0] host_addr,
    input logic           dlab,
    input logic           line_we,
    input logic [3:0]     line_wdata,
    input logic [7:0]     msr,
    input logic [DW-1:0]  dll,
    input logic [1:0]     irq_flags,
    input logic [1:0]     irq_clr
);
    logic msr_rd, scr_wr, dll_wr, dll_wr_blocked;
    assign msr_rd = host_sel && host_rd && host_addr == HAW'(6);
    assign scr_wr = host_sel && host_wr && !host_rd && host_addr == HAW'(7);
    assign dll_wr = host_sel && host_wr && dlab && host_addr == HAW'(0);
    assign dll_wr_blocked = host_sel && host_wr && !dlab && host_addr == HAW'(0);

    a_r2_lines_follow: assert property (@(posedge clk) disable iff (!rst_n)
        line_we |=> msr[7:4] == $past(line_wdata));
    a_r3_dcd_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (line_we && line_wdata[3] != msr[7]) |=> msr[3]);
    a_r3_cts_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (line_we && line_wdata[0] != msr[4]) |=> msr[0]);
    a_r4_ri_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (line_we && msr[6] && !line_wdata[2]) |=> msr[2]);
    a_r4_no_rise_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr[2] && !(line_we && msr[6] && !line_wdata[2])) |=> !msr[2]);
    a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (msr_rd && !line_we) |=> msr[3:0] == 4'b0000);
    a_r6_scr_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (scr_wr && irq_flags == 2'b00) |=> irq_flags == 2'b00);
    a_r7_dll_guard: assert property (@(posedge clk) disable iff (!rst_n)
        dll_wr_blocked |=> $stable(dll));
    a_r8_low_flag: assert property (@(posedge clk) disable iff (!rst_n)
        dll_wr |=> irq_flags[0]);
    a_r9_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[1] && !irq_clr[1]) |=> irq_flags[1]);
endmodule

bind uart_mirror_regs umr_checker #(.DW(DW), .HAW(HAW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .dlab       (dlab),
    .line_we    (line_we),
    .line_wdata (line_wdata),
    .msr        (msr_w),
    .dll        (dll_w),
    .irq_flags  (irq_flags),
    .irq_clr    (irq_clr)
);

// File: tb/sim_uart_mirror_regs.sv
`timescale 1ns/1ps
module sim_uart_mirror_regs;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_sel = 0, host_wr = 0, host_rd = 0, dlab = 0, line_we = 0;
    logic [2:0] host_addr = '0;
    logic [7:0] host_wdata = '0, loc_rd_addr = '0;
    logic [3:0] line_wdata = '0;
    logic [1:0] irq_clr = '0;
    logic [7:0] host_rdata, loc_rdata;
    logic       host_hit, irq_req;
    logic [1:0] irq_flags;

    int checks = 0;
    int failures = 0;

    // reference state
    logic [7:0] m_scr = 0, m_dll = 0, m_dlm = 0;
    logic [3:0] m_lines = 0, m_delta = 0;
    logic [1:0] m_flg = 0;

    always #10 clk = ~clk;

    uart_mirror_regs u0 (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_addr(host_addr), .host_wdata(host_wdata),
        .dlab(dlab), .host_rdata(host_rdata), .host_hit(host_hit),
        .line_we(line_we), .line_wdata(line_wdata), .loc_rd_addr(loc_rd_addr),
        .loc_rdata(loc_rdata), .irq_clr(irq_clr), .irq_flags(irq_flags),
        .irq_req(irq_req)
    );

    function automatic logic exp_hit(logic [2:0] a, logic dl);
        return (a == 3'd6) || (a == 3'd7) || (dl && (a == 3'd0 || a == 3'd1));
    endfunction

    function automatic logic [7:0] exp_host(logic [2:0] a, logic dl);
        if (a == 3'd7) return m_scr;
        if (a == 3'd6) return {m_lines, m_delta};
        if (dl && a == 3'd0) return m_dll;
        if (dl && a == 3'd1) return m_dlm;
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_loc(logic [7:0] a);
        if (a == 8'hF7) return m_scr;
        if (a == 8'hF8) return m_dll;
        if (a == 8'hF9) return m_dlm;
        return 8'h00;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string host_tag(logic [2:0] a);
        if (a == 3'd6) return "R5";
        if (a == 3'd7) return "R6";
        return "R7";
    endfunction

    // One cycle: drive at negedge, check same-cycle outputs, advance model at posedge.
    task automatic step(logic sel, logic wr, logic rd, logic [2:0] a, logic [7:0] wd,
                        logic dl, logic lwe, logic [3:0] lwd, logic [7:0] la,
                        logic [1:0] clr);
        logic [3:0] ev;
        logic [1:0] setf;
        host_sel = sel; host_wr = wr; host_rd = rd; host_addr = a;
        host_wdata = wd; dlab = dl; line_we = lwe; line_wdata = lwd;
        loc_rd_addr = la; irq_clr = clr;
        #1;
        if (sel && rd) chk({host_tag(a), " R11 rdata"}, host_rdata, exp_host(a, dl));
        else           chk("R11 idle rdata", host_rdata, 8'h00);
        chk("R7 hit", {7'd0, host_hit}, {7'd0, sel && (wr || rd) && exp_hit(a, dl)});
        chk("R10 local", loc_rdata, exp_loc(la));
        chk("R8 flags", {6'd0, irq_flags}, {6'd0, m_flg});
        chk("R8 irq_req", {7'd0, irq_req}, {7'd0, |m_flg});
        ev = '0;
        if (lwe) begin
            ev[3] = lwd[3] ^ m_lines[3];
            ev[2] = m_lines[2] & ~lwd[2];
            ev[1] = lwd[1] ^ m_lines[1];
            ev[0] = lwd[0] ^ m_lines[0];
        end
        setf = '0;
        @(posedge clk);
        m_delta = ((sel && rd && a == 3'd6) ? 4'b0 : m_delta) | ev;
        if (lwe) m_lines = lwd;
        if (sel && wr) begin
            if (a == 3'd7) m_scr = wd;
            if (dl && a == 3'd0) begin m_dll = wd; setf[0] = 1'b1; end
            if (dl && a == 3'd1) begin m_dlm = wd; setf[1] = 1'b1; end
        end
        m_flg = setf | (m_flg & ~clr);
        @(negedge clk);
    endtask

    task automatic idle();
        step(0, 0, 0, 3'd0, 8'h00, 0, 0, m_lines, 8'h00, 2'b00);
    endtask

    task automatic hread(logic [2:0] a, logic dl);
        step(1, 0, 1, a, 8'h00, dl, 0, m_lines, 8'hF7, 2'b00);
    endtask

    task automatic hwrite(logic [2:0] a, logic [7:0] d, logic dl);
        step(1, 1, 0, a, d, dl, 0, m_lines, 8'hF8, 2'b00);
    endtask

    task automatic lwrite(logic [3:0] v);
        step(0, 0, 0, 3'd0, 8'h00, 0, 1, v, 8'hF9, 2'b00);
    endtask

    initial begin
        #4_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset contents
        hread(3'd7, 1); hread(3'd0, 1); hread(3'd1, 1); hread(3'd6, 1);
        chk("R1 msr", {4'd0, m_lines}, 8'h00);
        // R2 / R3: line levels and change flags
        lwrite(4'b1010);
        hread(3'd6, 0);
        lwrite(4'b1010);            // same level again: no flag
        hread(3'd6, 0);
        lwrite(4'b0001);            // cts on, dcd/dsr off
        hread(3'd6, 0);
        // R4: ring rising then falling
        lwrite(4'b0101);
        hread(3'd6, 0);
        lwrite(4'b0001);
        hread(3'd6, 0);
        // R5: line change in the same cycle as the status read
        step(1, 0, 1, 3'd6, 8'h00, 0, 1, 4'b1001, 8'hF7, 2'b00);
        hread(3'd6, 0);
        hread(3'd6, 0);
        // R6: scratch write raises nothing
        hwrite(3'd7, 8'h5C, 0);
        hread(3'd7, 0);
        // R7: divisor gated by dlab
        hwrite(3'd0, 8'h33, 0);
        hwrite(3'd1, 8'h44, 0);
        hwrite(3'd6, 8'hFF, 1);
        hread(3'd3, 1);
        hread(3'd0, 1);
        // R8: divisor writes set flags
        hwrite(3'd0, 8'h0C, 1);
        hwrite(3'd1, 8'h01, 1);
        // R9: clear and set racing; set wins
        step(1, 1, 0, 3'd1, 8'h02, 1, 0, m_lines, 8'hF9, 2'b11);
        idle();
        step(0, 0, 0, 3'd0, 8'h00, 0, 0, m_lines, 8'hF8, 2'b10);
        idle();
        // R10: window edges
        step(0, 0, 0, 3'd0, 8'h00, 0, 0, m_lines, 8'hF6, 2'b00);
        step(0, 0, 0, 3'd0, 8'h00, 0, 0, m_lines, 8'hF7, 2'b00);
        step(0, 0, 0, 3'd0, 8'h00, 0, 0, m_lines, 8'hF8, 2'b00);
        step(0, 0, 0, 3'd0, 8'h00, 0, 0, m_lines, 8'hF9, 2'b00);
        step(0, 0, 0, 3'd0, 8'h00, 0, 0, m_lines, 8'hFA, 2'b00);
        // random phase
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] op;
            logic sel, wr, rd;
            op  = 4'($urandom_range(0, 9));
            sel = (op < 4'd7);
            wr  = sel && (op < 4'd3);
            rd  = sel && !wr;
            step(sel, wr, rd, 3'($urandom), 8'($urandom), 1'($urandom),
                 ($urandom_range(0, 2) == 0), 4'($urandom),
                 8'($urandom_range(8'hF5, 8'hFB)),
                 ($urandom_range(0, 3) == 0) ? 2'($urandom) : 2'b00);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule